// File: doc/BRIEF.md
# Strobe-Qualified DDR Read Data Capture

This block assembles DDR read bursts from samples taken by ordinary double-rate input registers. Both the data lines and the strobe are sampled on the rising and falling edges of one tunable capture clock. The strobe never clocks anything. Because the memory drives the strobe edge-aligned with the data during reads, one capture phase fits both, and each strobe sample is the qualifier for the data sample taken at the same instant.

The block looks for the read preamble in the strobe samples while the command side holds `rd_window` high. The preamble is at least two half-cycles of low strobe followed by the first high sample. On a preamble it resets the beat position. The first beat may land on either capture edge: on the rising edge (full-cycle alignment) or on the falling edge (half-cycle alignment, enabled by a parameter). The block then collects one burst of beats and packs it into a single wide word, which it presents for one cycle as a write to a read FIFO in the same clock domain.

If the strobe stops toggling part way through a burst, the burst is dropped and an error pulse is raised. During calibration the controller sets `train_en`, and `pat_match` reports whether the written word equals the fixed training pattern.

Top module: `ddrcap_read_capture`

## Requirements
- R1: After reset, and while no burst is in progress, `fifo_wr_en`, `burst_err` and `pat_match` are 0.
- R2: Full-cycle alignment: a capture cycle with `dqs_rise`=0 and `dqs_fall`=0, followed by a cycle with `dqs_rise`=1 and `dqs_fall`=0 while `rd_window`=1, starts a burst. That cycle's rising sample is beat 0 and its falling sample is beat 1. The next cycles supply beats 2 to 7 as (rising, falling) pairs.
- R3: Beat b of a burst appears in `fifo_wr_data[b*DQ_W +: DQ_W]`. `fifo_wr_en` is high for exactly one cycle, 4 cycles after the cycle that carried beat 0 in full-cycle alignment.
- R4: Half-cycle alignment: a cycle with `dqs_fall`=0, followed by a cycle with `dqs_rise`=0 and `dqs_fall`=1 while `rd_window`=1, starts a burst. That falling sample is beat 0, the next cycle's rising sample is beat 1, and so on. The word is written 5 cycles after the cycle that carried beat 0.
- R5: A preamble seen while `rd_window`=0 is ignored. No write and no error follow from it.
- R6: Within a burst, the strobe sample of every even beat must be 1 and that of every odd beat must be 0. On the first violation the burst is discarded: no write is made and `burst_err` pulses for one cycle. The block then waits for the next preamble.
- R7: Data seen while the strobe is held low or held high, without a preamble, never produces a write.
- R8: In a write cycle, `pat_match` is 1 exactly when `train_en`=1 and every beat b equals all ones if `TRAIN_SEQ[b]`=1, or all zeros if it is 0. Outside write cycles `pat_match` is 0.
- R9: Bursts separated only by their preamble each give one write, in arrival order. `fifo_wr_en` is never high in two consecutive cycles and is never high together with `burst_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tunable capture clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_window | input | 1 | Command side expects read data; gates preamble acceptance |
| train_en | input | 1 | Calibration mode: compare written words with the training pattern |
| dq_rise | input | DQ_W | Data lines sampled on the rising capture edge |
| dq_fall | input | DQ_W | Data lines sampled on the falling capture edge |
| dqs_rise | input | 1 | Strobe sampled on the rising capture edge |
| dqs_fall | input | 1 | Strobe sampled on the falling capture edge |
| fifo_wr_en | output | 1 | One-cycle write strobe for the read FIFO |
| fifo_wr_data | output | BURST_LEN*DQ_W | Packed burst, beat 0 in the low bits |
| burst_err | output | 1 | One-cycle pulse when a burst is truncated |
| pat_match | output | 1 | Training word matched, valid with fifo_wr_en |

## Verification
The assertions take it as given that `rd_window` covers the preamble cycle of every read. They also assume the strobe samples come from a clock phase that puts them inside the data eye, so that each sample is a clean 0 or 1 and not a metastable value. Under those conditions, write timing, the strobe pattern and the window relation can be checked from the ports alone. The bench builds every stimulus from a half-cycle stream of clean samples with a low preamble of at least two half-cycles. It drives `rd_window` for the whole burst and changes inputs only on the falling edge of the bench clock. Truncation and stuck-strobe cases are built from the same stream by forcing strobe values, so no sample is ever undefined.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;

   // Which capture edge carries beat 0 of the current burst.
   typedef enum logic {
      PH_FULL = 1'b0,   // beat 0 on the rising sample
      PH_HALF = 1'b1    // beat 0 on the falling sample
   } cap_phase_e;

   // A burst must hold at least two beat pairs.
   localparam int MIN_BURST = 4;

endpackage

// File: rtl/ddrcap_align.sv
module ddrcap_align #(
   parameter int DQ_W    = 8,
   parameter bit HALF_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            win,
   input  logic [DQ_W-1:0] dq_r,
   input  logic [DQ_W-1:0] dq_f,
   input  logic            s_r,
   input  logic            s_f,
   output logic            start_full,
   output logic            start_half,
   output logic [DQ_W-1:0] full_ev_dq,
   output logic [DQ_W-1:0] full_od_dq,
   output logic            full_ev_s,
   output logic            full_od_s,
   output logic [DQ_W-1:0] half_ev_dq,
   output logic [DQ_W-1:0] half_od_dq,
   output logic            half_ev_s,
   output logic            half_od_s
);

   // Strobe history from the previous capture cycle.
   logic prev_s_r;
   logic prev_s_f;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_s_r <= 1'b0;
         prev_s_f <= 1'b0;
      end else begin
         prev_s_r <= s_r;
         prev_s_f <= s_f;
      end
   end

   // Rising-edge pairing: (rise, fall) of one cycle.
   assign full_ev_dq = dq_r;
   assign full_od_dq = dq_f;
   assign full_ev_s  = s_r;
   assign full_od_s  = s_f;
   assign start_full = win & ~prev_s_r & ~prev_s_f & s_r & ~s_f;

   generate
      if (HALF_EN) begin : g_half
         logic [DQ_W-1:0] prev_dq_f;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_dq_f <= '0;
            else        prev_dq_f <= dq_f;
         end
         // Falling-edge pairing: previous fall with current rise.
         assign half_ev_dq = prev_dq_f;
         assign half_od_dq = dq_r;
         assign half_ev_s  = prev_s_f;
         assign half_od_s  = s_r;
         assign start_half = win & ~prev_s_f & ~s_r & s_f;
      end else begin : g_full_only
         assign half_ev_dq = dq_r;
         assign half_od_dq = dq_f;
         assign half_ev_s  = s_r;
         assign half_od_s  = s_f;
         assign start_half = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ddrcap_collect.sv
module ddrcap_collect
   import ddrcap_pkg::*;
#(
   parameter int DQ_W  = 8,
   parameter int PAIRS = 4,
   localparam int CW   = (PAIRS > 1) ? $clog2(PAIRS) : 1,
   localparam int PW   = 2 * DQ_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_full,
   input  logic              start_half,
   input  logic [DQ_W-1:0]   full_ev_dq,
   input  logic [DQ_W-1:0]   full_od_dq,
   input  logic              full_ev_s,
   input  logic              full_od_s,
   input  logic [DQ_W-1:0]   half_ev_dq,
   input  logic [DQ_W-1:0]   half_od_dq,
   input  logic              half_ev_s,
   input  logic              half_od_s,
   output logic              done,
   output logic              err,
   output logic [PAIRS*PW-1:0] word
);

   localparam logic [CW-1:0] LAST = CW'(PAIRS - 1);

   logic       busy;
   cap_phase_e phase;
   logic [CW-1:0] cnt;

   // Pair selected by the alignment chosen at preamble time.
   logic [PW-1:0] sel_pair;
   logic          pair_ok;
   always_comb begin
      if (phase == PH_HALF) begin
         sel_pair = {half_od_dq, half_ev_dq};
         pair_ok  = half_ev_s & ~half_od_s;
      end else begin
         sel_pair = {full_od_dq, full_ev_dq};
         pair_ok  = full_ev_s & ~full_od_s;
      end
   end

   // Slot load control: the rising-edge start carries pair 0 at once.
   logic          ld_en;
   logic [CW-1:0] ld_idx;
   logic [PW-1:0] ld_pair;
   always_comb begin
      ld_en   = busy ? pair_ok : start_full;
      ld_idx  = busy ? cnt : '0;
      ld_pair = busy ? sel_pair : {full_od_dq, full_ev_dq};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         phase <= PH_FULL;
         cnt   <= '0;
         done  <= 1'b0;
         err   <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (!busy) begin
            if (start_full) begin
               busy  <= 1'b1;
               phase <= PH_FULL;
               cnt   <= CW'(1);
            end else if (start_half) begin
               busy  <= 1'b1;
               phase <= PH_HALF;
               cnt   <= '0;
            end
         end else if (pair_ok) begin
            if (cnt == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            busy <= 1'b0;
            err  <= 1'b1;
         end
      end
   end

   // One storage slot per beat pair, even beat in the low half.
   generate
      for (genvar g = 0; g < PAIRS; g++) begin : g_slot
         logic [PW-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                             slot_q <= '0;
            else if (ld_en && ld_idx == CW'(g))     slot_q <= ld_pair;
         end
         assign word[g*PW +: PW] = slot_q;
      end
   endgenerate

endmodule

// File: rtl/ddrcap_read_capture.sv
module ddrcap_read_capture
   import ddrcap_pkg::*;
#(
   parameter int DQ_W                   = 8,
   parameter int BURST_LEN              = 8,
   parameter bit HALF_EN                = 1'b1,
   parameter logic [BURST_LEN-1:0] TRAIN_SEQ = 'hA5,
   localparam int PAIRS                 = BURST_LEN / 2,
   localparam int WORD_W                = BURST_LEN * DQ_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_window,
   input  logic              train_en,
   input  logic [DQ_W-1:0]   dq_rise,
   input  logic [DQ_W-1:0]   dq_fall,
   input  logic              dqs_rise,
   input  logic              dqs_fall,
   output logic              fifo_wr_en,
   output logic [WORD_W-1:0] fifo_wr_data,
   output logic              burst_err,
   output logic              pat_match
);

   // Elaboration-time parameter checks.
   generate
      if (BURST_LEN < MIN_BURST || (BURST_LEN % 2) != 0) begin : g_bad_len
         $error("BURST_LEN must be even and at least %0d", MIN_BURST);
      end
      if (DQ_W < 1) begin : g_bad_width
         $error("DQ_W must be at least 1");
      end
   endgenerate

   logic            st_full, st_half;
   logic [DQ_W-1:0] f_ev_dq, f_od_dq, h_ev_dq, h_od_dq;
   logic            f_ev_s, f_od_s, h_ev_s, h_od_s;
   logic            done, err;
   logic [WORD_W-1:0] word;

   ddrcap_align #(.DQ_W(DQ_W), .HALF_EN(HALF_EN)) u_align (
      .clk        (clk),
      .rst_n      (rst_n),
      .win        (rd_window),
      .dq_r       (dq_rise),
      .dq_f       (dq_fall),
      .s_r        (dqs_rise),
      .s_f        (dqs_fall),
      .start_full (st_full),
      .start_half (st_half),
      .full_ev_dq (f_ev_dq),
      .full_od_dq (f_od_dq),
      .full_ev_s  (f_ev_s),
      .full_od_s  (f_od_s),
      .half_ev_dq (h_ev_dq),
      .half_od_dq (h_od_dq),
      .half_ev_s  (h_ev_s),
      .half_od_s  (h_od_s)
   );

   ddrcap_collect #(.DQ_W(DQ_W), .PAIRS(PAIRS)) u_collect (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_full (st_full),
      .start_half (st_half),
      .full_ev_dq (f_ev_dq),
      .full_od_dq (f_od_dq),
      .full_ev_s  (f_ev_s),
      .full_od_s  (f_od_s),
      .half_ev_dq (h_ev_dq),
      .half_od_dq (h_od_dq),
      .half_ev_s  (h_ev_s),
      .half_od_s  (h_od_s),
      .done       (done),
      .err        (err),
      .word       (word)
   );

   // Training reference: each beat all ones or all zeros.
   logic [WORD_W-1:0] train_word;
   generate
      for (genvar b = 0; b < BURST_LEN; b++) begin : g_train
         assign train_word[b*DQ_W +: DQ_W] = {DQ_W{TRAIN_SEQ[b]}};
      end
   endgenerate

   assign fifo_wr_en   = done;
   assign fifo_wr_data = word;
   assign burst_err    = err;
   assign pat_match    = done & train_en & (word == train_word);

endmodule

// File: rtl/ddrcap_read_capture_chk.sv
module ddrcap_read_capture_chk #(
   parameter int BURST_LEN = 8,
   localparam int PAIRS    = BURST_LEN / 2,
   localparam int SW       = $clog2(BURST_LEN) + 2
) (
   input logic clk,
   input logic rst_n,
   input logic rd_window,
   input logic train_en,
   input logic dqs_rise,
   input logic dqs_fall,
   input logic fifo_wr_en,
   input logic burst_err,
   input logic pat_match
);

   // Cycles since rd_window was last seen high, saturating.
   logic [SW-1:0] since_win;
   always_ff @(posedge clk) begin
      if (!rst_n)                  since_win <= '1;
      else if (rd_window)          since_win <= '0;
      else if (since_win != '1)    since_win <= since_win + 1'b1;
   end

   // R5: a write must trace back to a preamble inside the window
   p_window_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_en |-> (since_win <= SW'(PAIRS)));

   // R6: the last beat pair seen before a write had strobe high then low
   p_last_pair_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_en |-> (($past(dqs_rise) && !$past(dqs_fall)) ||
                      (!$past(dqs_rise) && $past(dqs_fall, 2))));

   // R8: a pattern match only accompanies a write in training mode
   p_match_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pat_match |-> (fifo_wr_en && train_en));

   // R9: write strobe lasts one cycle
   p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_en |=> !fifo_wr_en);

   // R9: write and error are exclusive
   p_wr_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_wr_en && burst_err));

   // R6: error is a one-cycle pulse
   p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      burst_err |=> !burst_err);

endmodule

bind ddrcap_read_capture ddrcap_read_capture_chk #(.BURST_LEN(BURST_LEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_window  (rd_window),
   .train_en   (train_en),
   .dqs_rise   (dqs_rise),
   .dqs_fall   (dqs_fall),
   .fifo_wr_en (fifo_wr_en),
   .burst_err  (burst_err),
   .pat_match  (pat_match)
);

// File: tb/ddrcap_read_capture_tb_top.sv
`timescale 1ns/1ps
module ddrcap_read_capture_tb_top;

   localparam int DQ_W   = 8;
   localparam int BL     = 8;
   localparam int WORD_W = DQ_W * BL;
   localparam logic [BL-1:0] TSEQ = 8'hA5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_window = 1'b0;
   logic              train_en = 1'b0;
   logic [DQ_W-1:0]   dq_rise = '0;
   logic [DQ_W-1:0]   dq_fall = '0;
   logic              dqs_rise = 1'b0;
   logic              dqs_fall = 1'b0;
   logic              fifo_wr_en;
   logic [WORD_W-1:0] fifo_wr_data;
   logic              burst_err;
   logic              pat_match;

   always #4 clk = ~clk;   // 125 MHz

   ddrcap_read_capture #(.DQ_W(DQ_W), .BURST_LEN(BL), .HALF_EN(1'b1), .TRAIN_SEQ(TSEQ)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_window    (rd_window),
      .train_en     (train_en),
      .dq_rise      (dq_rise),
      .dq_fall      (dq_fall),
      .dqs_rise     (dqs_rise),
      .dqs_fall     (dqs_fall),
      .fifo_wr_en   (fifo_wr_en),
      .fifo_wr_data (fifo_wr_data),
      .burst_err    (burst_err),
      .pat_match    (pat_match)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // Output monitor, sampling away from the active edge.
   int n_wr, n_err, n_match, n_dbl, wr_cyc;
   logic [WORD_W-1:0] wlog [4];
   bit prev_wr = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (fifo_wr_en) begin
            if (n_wr < 4) wlog[n_wr] = fifo_wr_data;
            n_wr   = n_wr + 1;
            wr_cyc = cyc;
            if (pat_match) n_match = n_match + 1;
            if (prev_wr) n_dbl = n_dbl + 1;
         end else if (pat_match) begin
            n_match = n_match + 100;
         end
         if (burst_err) n_err = n_err + 1;
         prev_wr = fifo_wr_en;
      end
   end

   task automatic clear_mon();
      n_wr = 0; n_err = 0; n_match = 0; n_dbl = 0; wr_cyc = -1;
      for (int i = 0; i < 4; i++) wlog[i] = '0;
   endtask

   task automatic check(input bit ok, input string req, input logic [WORD_W-1:0] act,
                        input logic [WORD_W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   logic [DQ_W-1:0] bq [BL];

   function automatic logic [WORD_W-1:0] exp_word();
      logic [WORD_W-1:0] w;
      for (int b = 0; b < BL; b++) w[b*DQ_W +: DQ_W] = bq[b];
      return w;
   endfunction

   task automatic load_beats(input logic [DQ_W-1:0] base, input logic [DQ_W-1:0] step);
      for (int b = 0; b < BL; b++) bq[b] = base + DQ_W'(b) * step;
   endtask

   // Drive one burst as a half-cycle stream; stop_at forces strobe low from that beat.
   task automatic run_burst(input bit half, input bit win, input int stop_at,
                            input int tail, output int t0);
      logic [DQ_W-1:0] hd [16];
      logic            hs [16];
      int lead, n;
      lead = half ? 3 : 2;
      for (int i = 0; i < 16; i++) begin hd[i] = '0; hs[i] = 1'b0; end
      for (int b = 0; b < BL; b++) begin
         hd[lead+b] = bq[b];
         hs[lead+b] = ((b % 2) == 0) && (b < stop_at);
      end
      n = lead + BL + 2;
      if (n % 2) n++;
      t0 = -1;
      for (int c = 0; c < n/2; c++) begin
         @(negedge clk);
         rd_window = win;
         dq_rise   = hd[2*c];
         dq_fall   = hd[2*c+1];
         dqs_rise  = hs[2*c];
         dqs_fall  = hs[2*c+1];
         if (2*c == lead || 2*c+1 == lead) t0 = cyc;
      end
      repeat (tail) begin
         @(negedge clk);
         rd_window = 1'b0;
         dq_rise = '0; dq_fall = '0; dqs_rise = 1'b0; dqs_fall = 1'b0;
      end
   endtask

   task automatic t_reset();
      clear_mon();
      repeat (4) @(negedge clk);
      // R1: idle outputs after reset
      check(fifo_wr_en == 1'b0 && n_wr == 0, "R1 wr_en idle", WORD_W'(fifo_wr_en), '0);
      check(burst_err == 1'b0 && n_err == 0, "R1 err idle", WORD_W'(burst_err), '0);
      check(pat_match == 1'b0, "R1 match idle", WORD_W'(pat_match), '0);
   endtask

   task automatic t_full_align();
      int t0;
      clear_mon();
      load_beats(8'h11, 8'h13);
      run_burst(1'b0, 1'b1, BL, 8, t0);
      check(n_wr == 1, "R2 one write", WORD_W'(n_wr), WORD_W'(1));
      check(wlog[0] == exp_word(), "R3 beat order full", wlog[0], exp_word());
      check(wr_cyc - t0 == 4, "R3 latency full", WORD_W'(wr_cyc - t0), WORD_W'(4));
      check(n_err == 0, "R2 no error", WORD_W'(n_err), '0);
   endtask

   task automatic t_half_align();
      int t0;
      clear_mon();
      load_beats(8'hC3, 8'h29);
      run_burst(1'b1, 1'b1, BL, 8, t0);
      check(n_wr == 1, "R4 one write", WORD_W'(n_wr), WORD_W'(1));
      check(wlog[0] == exp_word(), "R4 beat order half", wlog[0], exp_word());
      check(wr_cyc - t0 == 5, "R4 latency half", WORD_W'(wr_cyc - t0), WORD_W'(5));
   endtask

   task automatic t_no_window();
      int t0;
      clear_mon();
      load_beats(8'h5A, 8'h07);
      run_burst(1'b0, 1'b0, BL, 8, t0);
      check(n_wr == 0, "R5 no write outside window", WORD_W'(n_wr), '0);
      check(n_err == 0, "R5 no error outside window", WORD_W'(n_err), '0);
   endtask

   task automatic t_truncated();
      int t0;
      clear_mon();
      load_beats(8'h80, 8'h01);
      run_burst(1'b0, 1'b1, 5, 8, t0);
      check(n_wr == 0, "R6 truncated burst dropped", WORD_W'(n_wr), '0);
      check(n_err == 1, "R6 single error pulse", WORD_W'(n_err), WORD_W'(1));
      // R6: the block recovers for the next burst
      clear_mon();
      load_beats(8'h3C, 8'h44);
      run_burst(1'b1, 1'b1, BL, 8, t0);
      check(n_wr == 1 && wlog[0] == exp_word(), "R6 recovery", wlog[0], exp_word());
   endtask

   task automatic t_stuck_strobe();
      clear_mon();
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         rd_window = 1'b1; dqs_rise = 1'b1; dqs_fall = 1'b1;
         dq_rise = DQ_W'(c * 37); dq_fall = DQ_W'(c * 91);
      end
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         rd_window = 1'b1; dqs_rise = 1'b0; dqs_fall = 1'b0;
         dq_rise = DQ_W'(c * 53); dq_fall = DQ_W'(c * 19);
      end
      repeat (8) begin
         @(negedge clk);
         rd_window = 1'b0; dq_rise = '0; dq_fall = '0;
      end
      // R7: strobe held high, then held low, gives nothing
      check(n_wr == 0, "R7 no write without preamble", WORD_W'(n_wr), '0);
   endtask

   task automatic t_training();
      int t0;
      clear_mon();
      for (int b = 0; b < BL; b++) bq[b] = {DQ_W{TSEQ[b]}};
      train_en = 1'b1;
      run_burst(1'b0, 1'b1, BL, 8, t0);
      check(n_wr == 1 && n_match == 1, "R8 pattern matched", WORD_W'(n_match), WORD_W'(1));
      clear_mon();
      bq[3] = 8'h01;
      run_burst(1'b1, 1'b1, BL, 8, t0);
      check(n_wr == 1 && n_match == 0, "R8 pattern mismatch", WORD_W'(n_match), '0);
      clear_mon();
      for (int b = 0; b < BL; b++) bq[b] = {DQ_W{TSEQ[b]}};
      train_en = 1'b0;
      run_burst(1'b0, 1'b1, BL, 8, t0);
      check(n_wr == 1 && n_match == 0, "R8 no match outside training", WORD_W'(n_match), '0);
   endtask

   task automatic t_back_to_back();
      int t0;
      logic [WORD_W-1:0] e0, e1;
      clear_mon();
      load_beats(8'h01, 8'h02);
      e0 = exp_word();
      run_burst(1'b0, 1'b1, BL, 0, t0);
      load_beats(8'hF0, 8'hFF);
      e1 = exp_word();
      run_burst(1'b1, 1'b1, BL, 8, t0);
      check(n_wr == 2, "R9 two writes", WORD_W'(n_wr), WORD_W'(2));
      check(wlog[0] == e0, "R9 first word order", wlog[0], e0);
      check(wlog[1] == e1, "R9 second word order", wlog[1], e1);
      check(n_dbl == 0, "R9 no consecutive writes", WORD_W'(n_dbl), '0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full_align();
      t_half_align();
      t_no_window();
      t_truncated();
      t_stuck_strobe();
      t_training();
      t_back_to_back();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule